// File: doc/BRIEF.md
# Effective Address Generator

This unit turns a decoded load operand specifier into a byte address. A request carries a mode code, an absolute address word, a 16-bit signed offset, an access size and two register indices. The unit reads the base and index registers through two combinational register-file read ports. It then presents the final address with a one-cycle valid strobe. A flag marks whether the address fits the access size.

Two modes do more than combine operands. The memory-indirect mode issues a read to a synchronous memory at the base register's value and uses the returned word as the address, which costs one extra cycle. The post-modify modes present the old base value as the address. In that same cycle they write the base register back, stepped up or down by the access size. A kill input abandons the request in flight, and no write-back or memory read then takes place.

Top module: `ea_unit`

## Requirements
- R1: During and right after reset the unit is idle: `req_ready` is 1, and `ea_valid`, `rf_we` and `mem_re` are 0.
- R2: Mode 0 (absolute): `ea_addr` equals `req_imm`, and `ea_valid` is high in the cycle after the request is accepted.
- R3: Mode 1 (register indirect): `ea_addr` equals the register named by `req_base`.
- R4: Mode 2 (displacement): `ea_addr` equals the base register plus `req_disp` sign-extended from 16 bits.
- R5: Mode 3 (indexed): `ea_addr` equals the base register plus the register named by `req_index`.
- R6: Mode 4 (memory indirect): in the cycle after acceptance, `mem_re` is high and `mem_raddr` holds the base register value. In the following cycle, `ea_valid` is high and `ea_addr` equals `mem_rdata`.
- R7: Modes 5 (post-increment) and 6 (post-decrement): `ea_addr` is the unmodified base register value. In the same cycle, `rf_we` writes the base register with its value plus (mode 5) or minus (mode 6) the step. The step is 1, 2 or 4 for `req_size` codes 0, 1 or 2 and above.
- R8: `kill` high while a request is in flight suppresses `ea_valid`, `rf_we` and `mem_re` in that cycle and returns the unit to idle. `kill` while idle has no effect.
- R9: `req_ready` is high only while idle. A request presented while the unit is busy is ignored.
- R10: `ea_misaligned` is high with `ea_valid` when the address is not a multiple of the step size. For `req_size` code 0 it is never high.
- R11: Mode 7 behaves exactly as mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe |
| req_ready | output | 1 | Unit idle and accepting |
| req_mode | input | 3 | Addressing mode code |
| req_imm | input | AW | Absolute address word |
| req_disp | input | DW | Signed offset |
| req_size | input | 2 | Access size code |
| req_base | input | RIW | Base register index |
| req_index | input | RIW | Index register index |
| kill | input | 1 | Abandon request in flight |
| rf_raddr_a | output | RIW | Base read port index |
| rf_rdata_a | input | AW | Base read data |
| rf_raddr_b | output | RIW | Index read port index |
| rf_rdata_b | input | AW | Index read data |
| rf_we | output | 1 | Base write-back enable |
| rf_waddr | output | RIW | Write-back register index |
| rf_wdata | output | AW | Updated base value |
| mem_re | output | 1 | Indirect read enable |
| mem_raddr | output | AW | Indirect read address |
| mem_rdata | input | AW | Indirect read data, one cycle after `mem_re` |
| ea_valid | output | 1 | Address valid strobe |
| ea_addr | output | AW | Effective address |
| ea_misaligned | output | 1 | Address not a multiple of the access size |

## Verification
The captured request fields, the sequencer state and the step selection are the only internal state. A stale or corrupted captured field appears at once, in the presentation cycle, as a wrong `ea_addr` or a wrong write-back value. A wrong state shows the same cycle as `req_ready` or `ea_valid` out of phase, or as a memory read that is missing or arrives late. A lost or wrong write-back stays hidden until a later request reads the same base register. Because of that, the stimulus reuses a small set of bases over many requests, and the reference register file accumulates every write-back.

// File: rtl/ea_unit.sv
module ea_unit #(
  parameter int AW  = 32,
  parameter int DW  = 16,
  parameter int RIW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic [2:0]     req_mode,
  input  logic [AW-1:0]  req_imm,
  input  logic [DW-1:0]  req_disp,
  input  logic [1:0]     req_size,
  input  logic [RIW-1:0] req_base,
  input  logic [RIW-1:0] req_index,
  input  logic           kill,
  output logic [RIW-1:0] rf_raddr_a,
  input  logic [AW-1:0]  rf_rdata_a,
  output logic [RIW-1:0] rf_raddr_b,
  input  logic [AW-1:0]  rf_rdata_b,
  output logic           rf_we,
  output logic [RIW-1:0] rf_waddr,
  output logic [AW-1:0]  rf_wdata,
  output logic           mem_re,
  output logic [AW-1:0]  mem_raddr,
  input  logic [AW-1:0]  mem_rdata,
  output logic           ea_valid,
  output logic [AW-1:0]  ea_addr,
  output logic           ea_misaligned
);
  typedef enum logic [1:0] {S_IDLE, S_EXEC, S_WAIT} st_t;
  st_t st;

  logic [2:0]     m_mode;
  logic [AW-1:0]  m_imm;
  logic [DW-1:0]  m_disp;
  logic [1:0]     m_size;
  logic [RIW-1:0] m_base, m_idx;
  logic [AW-1:0]  step, calc;

  wire is_ind  = (m_mode == 3'd4);
  wire is_auto = (m_mode == 3'd5) || (m_mode == 3'd6);
  wire [AW-1:0] disp_x = {{(AW-DW){m_disp[DW-1]}}, m_disp};

  always_ff @(posedge clk) begin
    if (!rst_n) st <= S_IDLE;
    else begin
      case (st)
        S_IDLE:  if (req_valid) st <= S_EXEC;
        S_EXEC:  st <= (is_ind && !kill) ? S_WAIT : S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (st == S_IDLE && req_valid) begin
      m_mode <= req_mode;
      m_imm  <= req_imm;
      m_disp <= req_disp;
      m_size <= req_size;
      m_base <= req_base;
      m_idx  <= req_index;
    end
  end

  always_comb begin
    case (m_size)
      2'd0:    step = AW'(1);
      2'd1:    step = AW'(2);
      default: step = AW'(4);
    endcase
  end

  always_comb begin
    case (m_mode)
      3'd1, 3'd5, 3'd6: calc = rf_rdata_a;
      3'd2:             calc = rf_rdata_a + disp_x;
      3'd3:             calc = rf_rdata_a + rf_rdata_b;
      default:          calc = m_imm;
    endcase
  end

  assign req_ready  = (st == S_IDLE);
  assign rf_raddr_a = m_base;
  assign rf_raddr_b = m_idx;

  assign ea_addr  = (st == S_WAIT) ? mem_rdata : calc;
  assign ea_valid = !kill && ((st == S_EXEC && !is_ind) || st == S_WAIT);

  assign rf_we    = (st == S_EXEC) && is_auto && !kill;
  assign rf_waddr = m_base;
  assign rf_wdata = (m_mode == 3'd6) ? rf_rdata_a - step : rf_rdata_a + step;

  assign mem_re    = (st == S_EXEC) && is_ind && !kill;
  assign mem_raddr = rf_rdata_a;

  assign ea_misaligned = ea_valid &&
    ((m_size == 2'd0) ? 1'b0 : (m_size == 2'd1) ? ea_addr[0] : |ea_addr[1:0]);
endmodule

// File: rtl/ea_unit_chk.sv
module ea_unit_chk (
  input logic clk,
  input logic rst_n,
  input logic req_valid,
  input logic req_ready,
  input logic kill,
  input logic ea_valid,
  input logic rf_we,
  input logic mem_re,
  input logic ea_misaligned
);
  assert_busy_after_accept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);
  assert_valid_not_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ea_valid && req_ready));
  assert_wb_with_addr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rf_we |-> ea_valid);
  assert_kill_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    kill |-> !ea_valid && !rf_we && !mem_re);
  assert_ind_then_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_re |=> (ea_valid || kill) && !req_ready);
  assert_flag_with_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ea_misaligned |-> ea_valid);
endmodule

bind ea_unit ea_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .kill(kill), .ea_valid(ea_valid), .rf_we(rf_we), .mem_re(mem_re),
  .ea_misaligned(ea_misaligned)
);

// File: tb/ea_unit_bench.sv
module ea_unit_bench;
  localparam int CLK_NS = 10;

  logic clk = 0, rst_n = 0;
  always #(CLK_NS/2) clk = ~clk;

  logic        req_valid = 0, kill = 0;
  logic        req_ready;
  logic [2:0]  req_mode = 0;
  logic [31:0] req_imm = 0;
  logic [15:0] req_disp = 0;
  logic [1:0]  req_size = 0;
  logic [4:0]  req_base = 0, req_index = 0;
  logic [4:0]  rf_raddr_a, rf_raddr_b, rf_waddr;
  logic [31:0] rf_rdata_a, rf_rdata_b, rf_wdata, mem_raddr, mem_rdata, ea_addr;
  logic        rf_we, mem_re, ea_valid, ea_misaligned;

  ea_unit u_ea_unit (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_imm(req_imm), .req_disp(req_disp), .req_size(req_size),
    .req_base(req_base), .req_index(req_index), .kill(kill),
    .rf_raddr_a(rf_raddr_a), .rf_rdata_a(rf_rdata_a),
    .rf_raddr_b(rf_raddr_b), .rf_rdata_b(rf_rdata_b),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .mem_re(mem_re), .mem_raddr(mem_raddr), .mem_rdata(mem_rdata),
    .ea_valid(ea_valid), .ea_addr(ea_addr), .ea_misaligned(ea_misaligned)
  );

  int errors = 0, checks = 0;
  logic [31:0] regs [32];
  logic [31:0] memq;

  assign rf_rdata_a = regs[rf_raddr_a];
  assign rf_rdata_b = regs[rf_raddr_b];
  assign mem_rdata  = memq;

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return a * 32'd7 + 32'h40;
  endfunction

  // reference model state
  int          ph;
  logic [2:0]  s_mode;
  logic [31:0] s_imm;
  logic [15:0] s_disp;
  logic [1:0]  s_size;
  logic [4:0]  s_b, s_x;

  always @(posedge clk) begin
    if (!rst_n) begin
      ph <= 0;
      for (int i = 0; i < 32; i++) regs[i] <= 32'h1000 + i * 32'h103;
    end else begin
      case (ph)
        0: if (req_valid) begin
             ph <= 1; s_mode <= req_mode; s_imm <= req_imm; s_disp <= req_disp;
             s_size <= req_size; s_b <= req_base; s_x <= req_index;
           end
        1: ph <= (s_mode == 3'd4 && !kill) ? 2 : 0;
        default: ph <= 0;
      endcase
      if (rf_we) regs[rf_waddr] <= rf_wdata;
    end
    if (mem_re) memq <= mem_word(mem_raddr);
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string mode_tag(input logic [2:0] m);
    case (m)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd7: return "R11";
      default: return "R7";
    endcase
  endfunction

  logic        e_val, e_we, e_mre, e_mis;
  logic [31:0] e_addr, e_wd, base, stp;
  bit          compare_on = 0;

  always @(negedge clk) begin
    if (rst_n && compare_on) begin
      base = regs[s_b];
      stp  = (s_size == 2'd0) ? 32'd1 : (s_size == 2'd1) ? 32'd2 : 32'd4;
      e_val = !kill && ((ph == 1 && s_mode != 3'd4) || ph == 2);
      case (s_mode)
        3'd1, 3'd5, 3'd6: e_addr = base;
        3'd2: e_addr = base + 32'($signed(s_disp));
        3'd3: e_addr = base + regs[s_x];
        default: e_addr = s_imm;
      endcase
      if (ph == 2) e_addr = memq;
      e_we  = ph == 1 && (s_mode == 3'd5 || s_mode == 3'd6) && !kill;
      e_wd  = (s_mode == 3'd6) ? base - stp : base + stp;
      e_mre = ph == 1 && s_mode == 3'd4 && !kill;
      e_mis = e_val && (e_addr % stp != 0);

      chk(req_ready == (ph == 0), "R9 ready", 32'(req_ready), 32'(ph == 0));
      chk(ea_valid == e_val, (kill && ph != 0) ? "R8 valid" : {mode_tag(s_mode), " valid"},
          32'(ea_valid), 32'(e_val));
      if (e_val) begin
        chk(ea_addr == e_addr, {mode_tag(s_mode), " addr"}, ea_addr, e_addr);
        chk(ea_misaligned == e_mis, "R10 flag", 32'(ea_misaligned), 32'(e_mis));
      end
      chk(rf_we == e_we, (kill && ph == 1) ? "R8 we" : "R7 we", 32'(rf_we), 32'(e_we));
      if (e_we) begin
        chk(rf_waddr == s_b, "R7 waddr", 32'(rf_waddr), 32'(s_b));
        chk(rf_wdata == e_wd, "R7 wdata", rf_wdata, e_wd);
      end
      chk(mem_re == e_mre, (kill && ph == 1) ? "R8 mem_re" : "R6 mem_re", 32'(mem_re), 32'(e_mre));
      if (e_mre) chk(mem_raddr == base, "R6 mem addr", mem_raddr, base);
    end
  end

  task automatic issue(input logic [2:0] m, input logic [31:0] imm, input logic [15:0] d,
                       input logic [1:0] sz, input logic [4:0] b, input logic [4:0] x,
                       input int kill_at, input bit hammer);
    @(posedge clk); #1;
    req_valid = 1; req_mode = m; req_imm = imm; req_disp = d;
    req_size = sz; req_base = b; req_index = x;
    @(posedge clk); #1;
    if (hammer) begin
      req_mode = 3'd1; req_base = b ^ 5'd3; req_imm = ~imm;
    end else req_valid = 0;
    kill = (kill_at == 1);
    @(posedge clk); #1;
    req_valid = 0; kill = (kill_at == 2);
    @(posedge clk); #1;
    kill = 0;
    @(posedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    lf = 32'hACE1_2357;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(req_ready == 1'b1, "R1 ready", 32'(req_ready), 32'd1);
    chk(ea_valid == 1'b0, "R1 valid", 32'(ea_valid), 32'd0);
    chk(rf_we == 1'b0, "R1 we", 32'(rf_we), 32'd0);
    chk(mem_re == 1'b0, "R1 mem_re", 32'(mem_re), 32'd0);
    rst_n = 1;
    compare_on = 1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 32'd1);

    issue(3'd0, 32'h0000_2000, 16'h0, 2'd2, 5'd0, 5'd0, 0, 0);     // R2
    issue(3'd0, 32'h0000_1001, 16'h0, 2'd1, 5'd0, 5'd0, 0, 0);     // R10 odd halfword
    issue(3'd0, 32'h0000_1002, 16'h0, 2'd1, 5'd0, 5'd0, 0, 0);     // R10 aligned halfword
    issue(3'd0, 32'h0000_1002, 16'h0, 2'd2, 5'd0, 5'd0, 0, 0);     // R10 misaligned word
    issue(3'd0, 32'h0000_1003, 16'h0, 2'd0, 5'd0, 5'd0, 0, 0);     // R10 byte never flagged
    issue(3'd1, 32'h0, 16'h0, 2'd2, 5'd4, 5'd0, 0, 0);             // R3
    issue(3'd2, 32'h0, 16'h0010, 2'd2, 5'd2, 5'd0, 0, 0);          // R4 positive
    issue(3'd2, 32'h0, 16'hFFF0, 2'd2, 5'd2, 5'd0, 0, 0);          // R4 negative
    issue(3'd3, 32'h0, 16'h0, 2'd2, 5'd3, 5'd7, 0, 0);             // R5
    issue(3'd4, 32'h0, 16'h0, 2'd2, 5'd5, 5'd0, 0, 0);             // R6
    issue(3'd5, 32'h0, 16'h0, 2'd0, 5'd6, 5'd0, 0, 0);             // R7 +1
    issue(3'd5, 32'h0, 16'h0, 2'd1, 5'd6, 5'd0, 0, 0);             // R7 +2
    issue(3'd5, 32'h0, 16'h0, 2'd2, 5'd6, 5'd0, 0, 0);             // R7 +4
    issue(3'd6, 32'h0, 16'h0, 2'd3, 5'd6, 5'd0, 0, 0);             // R7 -4
    issue(3'd1, 32'h0, 16'h0, 2'd2, 5'd6, 5'd0, 0, 0);             // R7 write-back visible
    issue(3'd5, 32'h0, 16'h0, 2'd2, 5'd8, 5'd0, 1, 0);             // R8 kill auto
    issue(3'd1, 32'h0, 16'h0, 2'd2, 5'd8, 5'd0, 0, 0);             // R8 base unchanged
    issue(3'd4, 32'h0, 16'h0, 2'd2, 5'd9, 5'd0, 1, 0);             // R8 kill before read
    issue(3'd4, 32'h0, 16'h0, 2'd2, 5'd9, 5'd0, 2, 0);             // R8 kill during wait
    issue(3'd4, 32'h0, 16'h0, 2'd2, 5'd9, 5'd0, 0, 1);             // R9 request while busy
    issue(3'd7, 32'h0000_3004, 16'h0, 2'd2, 5'd1, 5'd0, 0, 0);     // R11
    @(posedge clk); #1; kill = 1;                                   // R8 kill while idle
    @(posedge clk); #1; kill = 0;
    issue(3'd1, 32'h0, 16'h0, 2'd2, 5'd9, 5'd0, 0, 0);

    for (int i = 0; i < 80; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      issue(lf[2:0], lf, lf[23:8], lf[5:4], {2'b0, lf[8:6]}, {2'b0, lf[11:9]},
            (lf[15:12] == 4'd0) ? 1 : (lf[15:12] == 4'd1) ? 2 : 0, lf[16]);
    end

    repeat (3) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule